// File: doc/BRIEF.md
# Receive FIFO Error and Flag Status Register

This block is the 16-bit status word of a UART receiver that buffers words in a FIFO. The upper byte holds two live counts: how many words now waiting in the receive FIFO were tagged with a parity error, and how many with a framing error. A word adds to a count when it is pushed and subtracts from it when it is popped. These are not lifetime totals. Bits 3 and 2 give the framing and parity tags of the word at the head of the FIFO.

The remaining six bits of the lower byte are sticky flags. Raw event pulses from the rest of the serial unit set them. Software clears a flag in two steps. First it reads the flag as 1, and the block records that read for that flag alone. Then it writes 0 to that bit. Writing 1 never sets a flag. A 0 written to a flag that has not been observed set does nothing.

The block does not hold the receive data itself. It keeps a shadow queue of the two error tags for each word, so that it knows which tags leave the FIFO on each pop. The stimulus must match the real data FIFO: no pop while it is empty, and no push while it is full unless a pop happens in the same cycle.

Top module: `rx_err_stat_reg`

## Requirements
- R1: After reset the read value is 0x0060: both counts zero, the FIFO empty, the flags at bit 6 and bit 5 set, and every other bit 0.
- R2: Bits 15..12 equal the number of words held in the FIFO whose parity tag is set. A push and a pop of parity-tagged words in the same cycle leave the count unchanged.
- R3: Bits 11..8 equal the number of words held in the FIFO whose framing tag is set, with the same push and pop rule as R2.
- R4: With a FIFO depth of 16, a count of 16 is shown in its 4-bit field as 15.
- R5: Bit 3 shows the framing tag and bit 2 the parity tag of the word at the FIFO head. Both read 0 when the FIFO is empty.
- R6: A CPU write never sets a flag, whatever value is written to the flag bits.
- R7: A write of 0 to a set flag that has not been read as 1 since it was set leaves the flag set.
- R8: A write of 0 to a flag that was read as 1 since it was set clears it. The read permission is kept per flag, so a flag that was 0 at the time of the read is not cleared.
- R9: If a flag event arrives in the same cycle as a clearing write, the flag stays set and its read permission is cancelled.
- R10: Bits 15..8, bit 3 and bit 2 ignore CPU writes.
- R11: A one-cycle event pulse sets its flag on the next clock edge, at these positions: error summary bit 7, transmit-done bit 6, transmit-space bit 5, break bit 4, overrun bit 1, data-ready bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rx_push | input | 1 | A received word enters the FIFO |
| rx_push_perr | input | 1 | Parity tag of the pushed word |
| rx_push_ferr | input | 1 | Framing tag of the pushed word |
| rx_pop | input | 1 | The head word leaves the FIFO |
| cpu_rd | input | 1 | CPU read strobe for the register |
| cpu_wr | input | 1 | CPU write strobe for the register |
| cpu_wdata | input | 16 | CPU write data |
| evt_err | input | 1 | Event pulse for the error-summary flag |
| evt_tx_done | input | 1 | Event pulse for the transmit-done flag |
| evt_tx_space | input | 1 | Event pulse for the transmit-space flag |
| evt_break | input | 1 | Event pulse for the break flag |
| evt_overrun | input | 1 | Event pulse for the overrun flag |
| evt_data_rdy | input | 1 | Event pulse for the data-ready flag |
| rdata | output | 16 | Register read value |

## Verification
The assertions assume that the pop and push strobes follow the data FIFO's legal use: never a pop when the queue is empty, and never a push into a full queue without a pop in the same cycle. Under that assumption the two counts can never exceed the occupancy. The bench keeps its own queue of tags and builds its random push and pop decisions only from that queue's size, so it never leaves this envelope. The flag properties assume nothing about how the strobes are timed. For that reason the bench drives reads, writes and events together in every combination, including an event and a clearing write in the same cycle.

// File: rtl/rxes_pkg.sv
package rxes_pkg;
  localparam int NFLAG = 6;
  // flag index order: 0 error summary, 1 tx done, 2 tx space, 3 break, 4 overrun, 5 data ready
  localparam int FLAG_POS [NFLAG] = '{7, 6, 5, 4, 1, 0};
  localparam logic [NFLAG-1:0] FLAG_RST = 6'b000110;
  localparam int TAG_W = 2;  // bit 0 parity, bit 1 framing
  localparam int TAG_PAR = 0;
  localparam int TAG_FRM = 1;
  localparam int FIELD_W = 4;
endpackage

// File: rtl/rxes_rst_sync.sv
module rxes_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_sync = sync_q[1];
endmodule

// File: rtl/rxes_tag_fifo.sv
module rxes_tag_fifo #(
  parameter int DEPTH = 16,
  parameter int TW    = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic [TW-1:0]                push_tag,
  input  logic                         pop,
  output logic [TW-1:0]                head_tag,
  output logic [$clog2(DEPTH+1)-1:0]   occ
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int OCC_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [TW-1:0]    mem_q [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [OCC_W-1:0] occ_q, occ_d;
  logic             do_pop;

  assign do_pop = pop && (occ_q != '0);

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    occ_d  = occ_q;
    if (push)   wptr_d = (wptr_q == LAST) ? '0 : wptr_q + 1'b1;
    if (do_pop) rptr_d = (rptr_q == LAST) ? '0 : rptr_q + 1'b1;
    case ({push, do_pop})
      2'b10:   occ_d = occ_q + 1'b1;
      2'b01:   occ_d = occ_q - 1'b1;
      default: occ_d = occ_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      occ_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      occ_q  <= occ_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (push) begin
      mem_q[wptr_q] <= push_tag;
    end
  end

  assign head_tag = (occ_q == '0) ? '0 : mem_q[rptr_q];
  assign occ      = occ_q;
endmodule

// File: rtl/rxes_err_count.sv
module rxes_err_count #(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          inc,
  input  logic          dec,
  output logic [CW-1:0] cnt
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    case ({inc, dec})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/rxes_flag_cell.sv
module rxes_flag_cell #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic evt,
  input  logic rd,
  input  logic wr,
  input  logic wbit,
  output logic flag,
  output logic armed
);
  logic flag_q, flag_d, arm_q, arm_d, clr;

  always_comb begin
    clr    = wr && !wbit && arm_q && flag_q;
    flag_d = evt || (flag_q && !clr);
    if (clr)               arm_d = 1'b0;
    else if (rd && flag_q) arm_d = 1'b1;
    else                   arm_d = arm_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      arm_q  <= arm_d;
    end
  end

  assign flag  = flag_q;
  assign armed = arm_q;
endmodule

// File: rtl/rx_err_stat_reg.sv
module rx_err_stat_reg #(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        rx_push,
  input  logic        rx_push_perr,
  input  logic        rx_push_ferr,
  input  logic        rx_pop,
  input  logic        cpu_rd,
  input  logic        cpu_wr,
  input  logic [15:0] cpu_wdata,
  input  logic        evt_err,
  input  logic        evt_tx_done,
  input  logic        evt_tx_space,
  input  logic        evt_break,
  input  logic        evt_overrun,
  input  logic        evt_data_rdy,
  output logic [15:0] rdata
);
  import rxes_pkg::*;

  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FIELD_MAX = CW'((1 << FIELD_W) - 1);

  logic                rst_n_sync;
  logic [TAG_W-1:0]    head_tag;
  logic [CW-1:0]       occ;
  logic [CW-1:0]       cnt [TAG_W];
  logic [FIELD_W-1:0]  field [TAG_W];
  logic [NFLAG-1:0]    flag_evt, flag_q, arm_q;
  logic                pop_ok;
  logic                unused_wbits;

  rxes_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  rxes_tag_fifo #(.DEPTH(DEPTH), .TW(TAG_W)) u_tags (
    .clk      (clk),
    .rst_n    (rst_n_sync),
    .push     (rx_push),
    .push_tag ({rx_push_ferr, rx_push_perr}),
    .pop      (rx_pop),
    .head_tag (head_tag),
    .occ      (occ)
  );

  assign pop_ok = rx_pop && (occ != '0);

  generate
    for (genvar k = 0; k < TAG_W; k++) begin : g_cnt
      logic push_tag_k;
      assign push_tag_k = (k == TAG_PAR) ? rx_push_perr : rx_push_ferr;
      rxes_err_count #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .inc   (rx_push && push_tag_k),
        .dec   (pop_ok && head_tag[k]),
        .cnt   (cnt[k])
      );
      assign field[k] = (cnt[k] > FIELD_MAX) ? FIELD_MAX[FIELD_W-1:0] : cnt[k][FIELD_W-1:0];
    end
  endgenerate

  assign flag_evt = {evt_data_rdy, evt_overrun, evt_break, evt_tx_space, evt_tx_done, evt_err};

  generate
    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
      rxes_flag_cell #(.RST_VAL(FLAG_RST[i])) u_flag (
        .clk   (clk),
        .rst_n (rst_n_sync),
        .evt   (flag_evt[i]),
        .rd    (cpu_rd),
        .wr    (cpu_wr),
        .wbit  (cpu_wdata[FLAG_POS[i]]),
        .flag  (flag_q[i]),
        .armed (arm_q[i])
      );
    end
  endgenerate

  assign unused_wbits = ^{cpu_wdata[15:8], cpu_wdata[3:2]};

  always_comb begin
    rdata        = '0;
    rdata[15:12] = field[TAG_PAR];
    rdata[11:8]  = field[TAG_FRM];
    rdata[3]     = head_tag[TAG_FRM];
    rdata[2]     = head_tag[TAG_PAR];
    for (int i = 0; i < NFLAG; i++) rdata[FLAG_POS[i]] = flag_q[i];
  end
endmodule

// File: rtl/rx_err_stat_reg_chk.sv
module rx_err_stat_reg_chk #(
  parameter int DEPTH = 16
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        rx_push,
  input logic                        rx_push_perr,
  input logic                        rx_pop,
  input logic                        cpu_wr,
  input logic [5:0]                  flag_evt,
  input logic [5:0]                  flag_q,
  input logic [5:0]                  arm_q,
  input logic [$clog2(DEPTH+1)-1:0]  cnt_par,
  input logic [$clog2(DEPTH+1)-1:0]  cnt_frm,
  input logic [$clog2(DEPTH+1)-1:0]  occ,
  input logic [15:0]                 rdata
);
  a_r2_par_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_par <= occ);

  a_r3_frm_within_occ: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_frm <= occ);

  a_r2_par_balance: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_push_perr && rx_pop && rdata[2]) |=> $stable(cnt_par));

  a_r5_empty_head_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (occ == '0) |-> (rdata[3:2] == 2'b00));

  a_r6_write_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_evt == '0) |=> ((flag_q & ~$past(flag_q)) == '0));

  a_r8_clear_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(flag_q) & ~flag_q & ~$past(arm_q)) == '0));

  a_r9_perm_only_when_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((arm_q & ~flag_q) == '0));

  a_r10_upper_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_wr && !rx_push && !rx_pop) |=> $stable(rdata[15:8]));
endmodule

bind rx_err_stat_reg rx_err_stat_reg_chk #(.DEPTH(DEPTH)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n_sync),
  .rx_push      (rx_push),
  .rx_push_perr (rx_push_perr),
  .rx_pop       (rx_pop),
  .cpu_wr       (cpu_wr),
  .flag_evt     (flag_evt),
  .flag_q       (flag_q),
  .arm_q        (arm_q),
  .cnt_par      (cnt[0]),
  .cnt_frm      (cnt[1]),
  .occ          (occ),
  .rdata        (rdata)
);

// File: tb/rx_err_stat_reg_bench.sv
module rx_err_stat_reg_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_push = 0, rx_push_perr = 0, rx_push_ferr = 0, rx_pop = 0;
  logic cpu_rd = 0, cpu_wr = 0;
  logic [15:0] cpu_wdata = '0;
  logic [5:0] evt = '0;  // 0 err,1 tx done,2 tx space,3 break,4 overrun,5 data ready
  logic [15:0] rdata;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  logic [1:0] mq[$];             // tag model: bit0 parity, bit1 framing
  logic [5:0] mflag = 6'b000110;
  logic [5:0] marm  = '0;
  int pos [6] = '{7, 6, 5, 4, 1, 0};

  always #10 clk = ~clk;

  rx_err_stat_reg #(.DEPTH(DEPTH)) u_rx_err_stat_reg (
    .clk(clk), .rst_n(rst_n),
    .rx_push(rx_push), .rx_push_perr(rx_push_perr), .rx_push_ferr(rx_push_ferr),
    .rx_pop(rx_pop), .cpu_rd(cpu_rd), .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata),
    .evt_err(evt[0]), .evt_tx_done(evt[1]), .evt_tx_space(evt[2]),
    .evt_break(evt[3]), .evt_overrun(evt[4]), .evt_data_rdy(evt[5]),
    .rdata(rdata)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int count_tag(input int b);
    int n = 0;
    foreach (mq[i]) if (mq[i][b]) n++;
    return n;
  endfunction

  function automatic logic [15:0] model_rdata();
    logic [15:0] v = '0;
    int p = count_tag(0);
    int f = count_tag(1);
    v[15:12] = (p > 15) ? 4'hF : 4'(p);
    v[11:8]  = (f > 15) ? 4'hF : 4'(f);
    if (mq.size() > 0) begin
      v[3] = mq[0][1];
      v[2] = mq[0][0];
    end
    for (int i = 0; i < 6; i++) v[pos[i]] = mflag[i];
    return v;
  endfunction

  task automatic compare_all();
    logic [15:0] e = model_rdata();
    check((count_tag(0) > 15) ? "R4 parity field" : "R2 parity field",
          {12'h0, rdata[15:12]}, {12'h0, e[15:12]});
    check((count_tag(1) > 15) ? "R4 framing field" : "R3 framing field",
          {12'h0, rdata[11:8]}, {12'h0, e[11:8]});
    check("R5 head tags", {14'h0, rdata[3:2]}, {14'h0, e[3:2]});
    check("R11 flag byte", {8'h0, rdata[7:4], 2'b00, rdata[1:0]}, {8'h0, e[7:4], 2'b00, e[1:0]});
  endtask

  // apply current inputs to the model, clock once, clear strobes
  task automatic step();
    for (int i = 0; i < 6; i++) begin
      logic clr = cpu_wr && !cpu_wdata[pos[i]] && marm[i] && mflag[i];
      logic nf  = evt[i] || (mflag[i] && !clr);
      logic na  = clr ? 1'b0 : ((cpu_rd && mflag[i]) ? 1'b1 : marm[i]);
      mflag[i] = nf;
      marm[i]  = na;
    end
    if (rx_pop && mq.size() > 0) void'(mq.pop_front());
    if (rx_push) mq.push_back({rx_push_ferr, rx_push_perr});
    @(posedge clk);
    #1;
    rx_push = 0; rx_push_perr = 0; rx_push_ferr = 0; rx_pop = 0;
    cpu_rd = 0; cpu_wr = 0; cpu_wdata = '0; evt = '0;
  endtask

  task automatic push(input logic p, input logic f);
    rx_push = 1; rx_push_perr = p; rx_push_ferr = f;
    step();
  endtask

  initial begin : watchdog
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cycles);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin : main
    repeat (3) @(posedge clk);
    #1;
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1 reset value", rdata, 16'h0060);

    // R6 / R10: writing ones changes nothing
    cpu_wr = 1; cpu_wdata = 16'hFFFF; step();
    check("R6 write ones no set", rdata, 16'h0060);
    cpu_wr = 1; cpu_wdata = 16'h0000; step();
    check("R7 zero write unread keeps flags", rdata, 16'h0060);

    // R5 / R2 / R3 directed pushes, each tag pattern
    push(1, 0); compare_all();
    check("R5 head parity", {14'h0, rdata[3:2]}, 16'h0001);
    push(0, 1); push(1, 1); push(0, 0); compare_all();
    check("R2 R3 counts", {8'h0, rdata[15:8]}, 16'h0022);
    cpu_wr = 1; cpu_wdata = 16'hFFFF; step();
    check("R10 upper and head ignore write", {8'h0, rdata[15:8]}, 16'h0022);
    check("R10 head bits ignore write", {14'h0, rdata[3:2]}, 16'h0001);
    // simultaneous push and pop of parity-tagged words
    rx_pop = 1; rx_push = 1; rx_push_perr = 1; step();
    check("R2 push+pop keeps count", {12'h0, rdata[15:12]}, 16'h0002);
    while (mq.size() > 0) begin rx_pop = 1; step(); compare_all(); end
    check("R5 empty head zero", {14'h0, rdata[3:2]}, 16'h0000);

    // R4 saturation: fill 16 words, all tagged
    for (int i = 0; i < DEPTH; i++) push(1, 1);
    check("R4 saturate at 15", {8'h0, rdata[15:8]}, 16'h00FF);
    rx_pop = 1; step();
    check("R4 fifteen after pop", {8'h0, rdata[15:8]}, 16'h00FF);
    rx_pop = 1; step();
    check("R4 fourteen", {8'h0, rdata[15:8]}, 16'h00EE);
    while (mq.size() > 0) begin rx_pop = 1; step(); end
    compare_all();

    // R11 each event at its bit position
    for (int i = 0; i < 6; i++) begin
      evt[i] = 1; step();
      check("R11 event position", {15'h0, rdata[pos[i]]}, 16'h0001);
    end

    // R8 clear after read
    cpu_rd = 1; step();
    cpu_wr = 1; cpu_wdata = 16'h0000; step();
    check("R8 read then clear", {8'h0, rdata[7:0]}, 16'h0000);
    // R8 per-flag permission
    evt[3] = 1; step();
    cpu_rd = 1; step();
    evt[4] = 1; step();
    cpu_wr = 1; cpu_wdata = 16'h0000; step();
    check("R8 per-flag permission", {8'h0, rdata[7:0]}, 16'h0002);
    // R9 event wins, permission cancelled
    cpu_rd = 1; step();
    cpu_wr = 1; cpu_wdata = 16'h0000; evt[4] = 1; step();
    check("R9 event same cycle as clear", {8'h0, rdata[7:0]}, 16'h0002);
    cpu_wr = 1; cpu_wdata = 16'h0000; step();
    check("R9 permission cancelled", {8'h0, rdata[7:0]}, 16'h0002);
    // R7 write 1 to an armed flag keeps it
    cpu_rd = 1; step();
    cpu_wr = 1; cpu_wdata = 16'h0002; step();
    check("R7 one write keeps armed flag", {8'h0, rdata[7:0]}, 16'h0002);
    cpu_wr = 1; cpu_wdata = 16'h0000; step();
    check("R8 clear after kept", {8'h0, rdata[7:0]}, 16'h0000);

    // random sweep within legal FIFO use
    for (int n = 0; n < 4000; n++) begin
      logic do_pop = (mq.size() > 0) && ($urandom_range(0, 2) == 0);
      logic do_push = ($urandom_range(0, 1) == 1) && ((mq.size() < DEPTH) || do_pop);
      rx_pop = do_pop;
      rx_push = do_push;
      rx_push_perr = ($urandom_range(0, 3) != 0);
      rx_push_ferr = ($urandom_range(0, 2) != 0);
      cpu_rd = ($urandom_range(0, 3) == 0);
      cpu_wr = ($urandom_range(0, 3) == 0);
      cpu_wdata = 16'($urandom);
      for (int i = 0; i < 6; i++) evt[i] = ($urandom_range(0, 7) == 0);
      step();
      compare_all();
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule